// File: doc/BRIEF.md
# Four-Step Event Sequence Trigger

This block watches a vector of single-cycle event pulses from an upstream matcher and holds four independent sequence recognisers. Each recogniser is set up with four ordered slots. A slot either names one event line or is marked as a wildcard that is skipped. When a recogniser has seen the events of its real slots in order, it fires the action it is set up for and rewinds to its first slot.

There are four actions: open collection, take an address sample, take an address-plus-data sample, and close collection. The block keeps a collecting flag that the open and close actions drive. The sample actions only happen while collecting is set, so a capture layer downstream can record just the first few transfers after each arming event. A typical setup uses one recogniser to arm on a status write. Two more recognisers sample the address and data of each transfer. The fourth counts two address/data pairs and then closes the window.

All configuration inputs are treated as static. They are changed only while reset is held.

Top module: `seqtrig_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, every strobe and the collecting flag read 0, and every recogniser is at its first slot.
- R2: A recogniser advances only on the event of its current real slot. Any other event has no effect. It advances by at most one slot per cycle, even when several of its events pulse together.
- R3: A slot whose wildcard bit is 1 is skipped, wherever it sits. A recogniser fires on its last non-wildcard slot, so trailing wildcards do not delay it. A recogniser with all four slots wildcarded never fires.
- R4: A recogniser programmed A, B, A, B fires only after two complete A-then-B pairs. It does not fire after the first pair.
- R5: After firing, a recogniser returns to its first slot and can fire again on a later repetition of its sequence.
- R6: Action codes are 0 = open, 1 = address sample, 2 = data sample, 3 = close. Recogniser n uses act_i[2n+1:2n]. The matching strobe is high for exactly the one cycle after the cycle in which the final event was seen.
- R7: An open action sets collecting_o in the same cycle as start_o. A close action clears it in the same cycle as stop_o. Collecting never rises without start_o.
- R8: Recognisers whose action is not open neither advance nor fire while collecting is clear. Events seen then are ignored, so no sample or stop strobes occur outside a window.
- R9: A close action returns every recogniser to its first slot. Progress that a sample recogniser made before the close is lost.
- R10: If an open and a close fire in the same cycle, the close wins. collecting_o goes to 0, stop_o pulses, and start_o stays 0.
- R11: Sample recognisers fire on every completed match inside a window, so one window can produce several sample strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | Event pulses from the matcher, one line per event |
| slot_sel_i | input | NUM_SEQ*NUM_SLOT*clog2(NUM_EVT) | Event index for slot k of recogniser n at field (n*NUM_SLOT+k) |
| slot_ign_i | input | NUM_SEQ*NUM_SLOT | Wildcard bit for slot k of recogniser n at bit n*NUM_SLOT+k |
| act_i | input | 2*NUM_SEQ | Action code per recogniser |
| start_o | output | 1 | Open-collection strobe |
| asmp_o | output | 1 | Address-sample strobe |
| dsmp_o | output | 1 | Address-plus-data sample strobe |
| stop_o | output | 1 | Close-collection strobe |
| collecting_o | output | 1 | Capture window is open |

## Verification
The hardest cases to reach from the ports depend on a recogniser that is partway through its sequence at the exact cycle another one fires. The first is an open and a close firing in the same cycle. The second is a close wiping the progress of a sample recogniser that is halfway through. The bench reaches both by switching to a second configuration. In that configuration the open recogniser has a wildcard gap and needs two events, the close recogniser needs one event, and the data-sample recogniser needs two. The bench first opens a window. To reach the collision, it feeds the open recogniser its first event and then pulses the open recogniser's second event together with the close event. To reach the lost progress, it feeds the sample recogniser half its pair, closes the window, reopens it, and shows that the second half alone no longer fires.

// File: rtl/seqtrig_pkg.sv
// Shared types for the sequence trigger: action encoding and field width.
package seqtrig_pkg;
    localparam int ACT_W = 2;

    typedef enum logic [ACT_W-1:0] {
        ACT_START   = 2'd0,
        ACT_ASAMPLE = 2'd1,
        ACT_DSAMPLE = 2'd2,
        ACT_STOP    = 2'd3
    } act_e;
endpackage

// File: rtl/seqtrig_recog.sv
// One ordered-event recogniser.
// Holds a count of real (non-wildcard) slots already matched. Each cycle the
// slot list is scanned to find the selector of the next real slot; a pulse on
// that event advances the count, and the last real slot fires and rewinds.
// Assumes slot configuration is static outside reset.
module seqtrig_recog #(
    parameter int NUM_EVT  = 8,
    parameter int NUM_SLOT = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  run_i,
    input  logic                                  clear_i,
    input  logic [NUM_EVT-1:0]                    evt_i,
    input  logic [NUM_SLOT*$clog2(NUM_EVT)-1:0]   sel_i,
    input  logic [NUM_SLOT-1:0]                   ign_i,
    output logic                                  fire_o
);
    localparam int SEL_W = $clog2(NUM_EVT);
    localparam int CNT_W = $clog2(NUM_SLOT + 1);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] nreal;
    logic [SEL_W-1:0] cur_sel;
    logic             hit;
    logic             last;

    // Locate the selector of the pos_q-th real slot and count real slots.
    always_comb begin
        nreal   = '0;
        cur_sel = '0;
        for (int k = 0; k < NUM_SLOT; k++) begin
            if (!ign_i[k]) begin
                if (nreal == pos_q) cur_sel = sel_i[k*SEL_W +: SEL_W];
                nreal = nreal + CNT_W'(1);
            end
        end
    end

    // Match the current slot's event and detect completion.
    always_comb begin
        hit    = run_i && (nreal != '0) && evt_i[cur_sel];
        last   = (pos_q == nreal - CNT_W'(1));
        fire_o = hit && last;
    end

    // Advance, rewind on completion, or rewind on a global clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (clear_i) pos_q <= '0;
        else if (hit)     pos_q <= last ? '0 : pos_q + CNT_W'(1);
    end

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(pos_q));
    assert_fire_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (pos_q == '0));
    assert_clear_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pos_q == '0));
    assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nreal != '0) |-> (pos_q < nreal));
endmodule

// File: rtl/seqtrig_action.sv
// Action combiner and capture-window state.
// Merges recogniser fires by their action code, keeps the collecting flag
// (close beats open) and registers one-cycle strobes. Assumes recognisers
// other than open ones are already held idle while the window is closed.
module seqtrig_action
    import seqtrig_pkg::*;
#(
    parameter int NUM_SEQ = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SEQ-1:0]       fire_i,
    input  logic [NUM_SEQ*ACT_W-1:0] act_i,
    output logic                     stop_now_o,
    output logic                     collecting_o,
    output logic                     start_o,
    output logic                     asmp_o,
    output logic                     dsmp_o,
    output logic                     stop_o
);
    logic any_start, any_asmp, any_dsmp, any_stop;
    logic coll_q, start_q, asmp_q, dsmp_q, stop_q;

    // OR together the fires that share each action code.
    always_comb begin
        any_start = 1'b0;
        any_asmp  = 1'b0;
        any_dsmp  = 1'b0;
        any_stop  = 1'b0;
        for (int s = 0; s < NUM_SEQ; s++) begin
            if (fire_i[s]) begin
                case (act_e'(act_i[s*ACT_W +: ACT_W]))
                    ACT_START:   any_start = 1'b1;
                    ACT_ASAMPLE: any_asmp  = 1'b1;
                    ACT_DSAMPLE: any_dsmp  = 1'b1;
                    ACT_STOP:    any_stop  = 1'b1;
                endcase
            end
        end
        stop_now_o = any_stop;
    end

    // Update the window flag and register the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q  <= 1'b0;
            start_q <= 1'b0;
            asmp_q  <= 1'b0;
            dsmp_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            coll_q  <= any_stop ? 1'b0 : (any_start ? 1'b1 : coll_q);
            start_q <= any_start && !any_stop;
            asmp_q  <= any_asmp;
            dsmp_q  <= any_dsmp;
            stop_q  <= any_stop;
        end
    end

    assign collecting_o = coll_q;
    assign start_o      = start_q;
    assign asmp_o       = asmp_q;
    assign dsmp_o       = dsmp_q;
    assign stop_o       = stop_q;

    assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> collecting_o);
    assert_rise_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collecting_o) |-> start_o);
    assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!collecting_o && !start_o));
    assert_sample_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (asmp_o || dsmp_o) |-> $past(collecting_o));
endmodule

// File: rtl/seqtrig_top.sv
// Four-step event sequence trigger.
// A bank of NUM_SEQ recognisers feeds the action combiner. Open recognisers
// always run; all others run only while the capture window is open. A close
// action clears every recogniser. Configuration is static outside reset.
module seqtrig_top
    import seqtrig_pkg::*;
#(
    parameter int NUM_EVT  = 8,
    parameter int NUM_SEQ  = 4,
    parameter int NUM_SLOT = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_EVT-1:0]                            evt_i,
    input  logic [NUM_SEQ*NUM_SLOT*$clog2(NUM_EVT)-1:0]   slot_sel_i,
    input  logic [NUM_SEQ*NUM_SLOT-1:0]                   slot_ign_i,
    input  logic [NUM_SEQ*ACT_W-1:0]                      act_i,
    output logic                                          start_o,
    output logic                                          asmp_o,
    output logic                                          dsmp_o,
    output logic                                          stop_o,
    output logic                                          collecting_o
);
    localparam int SEL_W    = $clog2(NUM_EVT);
    localparam int SEQ_SELW = NUM_SLOT * SEL_W;

    logic [NUM_SEQ-1:0] fire;
    logic [NUM_SEQ-1:0] run;
    logic               stop_now;
    logic               coll;

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
        // Open recognisers arm the window; others wait for it.
        assign run[g] = (act_i[g*ACT_W +: ACT_W] == ACT_START) || coll;

        seqtrig_recog #(
            .NUM_EVT (NUM_EVT),
            .NUM_SLOT(NUM_SLOT)
        ) u_recog (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run[g]),
            .clear_i(stop_now),
            .evt_i  (evt_i),
            .sel_i  (slot_sel_i[g*SEQ_SELW +: SEQ_SELW]),
            .ign_i  (slot_ign_i[g*NUM_SLOT +: NUM_SLOT]),
            .fire_o (fire[g])
        );
    end

    seqtrig_action #(
        .NUM_SEQ(NUM_SEQ)
    ) u_action (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .act_i       (act_i),
        .stop_now_o  (stop_now),
        .collecting_o(coll),
        .start_o     (start_o),
        .asmp_o      (asmp_o),
        .dsmp_o      (dsmp_o),
        .stop_o      (stop_o)
    );

    assign collecting_o = coll;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !(start_o || asmp_o || dsmp_o || stop_o || collecting_o));
endmodule

// File: tb/seqtrig_top_test.sv
`timescale 1ns/1ps
module seqtrig_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic [47:0] slot_sel;
    logic [15:0] slot_ign;
    logic [7:0]  act;
    logic        start_o, asmp_o, dsmp_o, stop_o, collecting_o;

    int cfg_sel[4][4];
    bit cfg_ign[4][4];
    int cfg_act[4];

    int m_pos[4];
    bit m_coll;
    bit e_start, e_asmp, e_dsmp, e_stop, e_coll;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int s = 0; s < 4; s++) begin
            act[s*2 +: 2] = 2'(cfg_act[s]);
            for (int k = 0; k < 4; k++) begin
                slot_sel[(s*4+k)*3 +: 3] = 3'(cfg_sel[s][k]);
                slot_ign[s*4+k]          = cfg_ign[s][k];
            end
        end
    end

    seqtrig_top uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .slot_sel_i(slot_sel), .slot_ign_i(slot_ign), .act_i(act),
        .start_o(start_o), .asmp_o(asmp_o), .dsmp_o(dsmp_o),
        .stop_o(stop_o), .collecting_o(collecting_o)
    );

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, actual, expected, $time);
        end
    endtask

    task automatic set_seq(input int s, input int a, input int e0, input int e1,
                           input int e2, input int e3);
        int ev[4];
        ev = '{e0, e1, e2, e3};
        cfg_act[s] = a;
        for (int k = 0; k < 4; k++) begin
            cfg_ign[s][k] = (ev[k] < 0);
            cfg_sel[s][k] = (ev[k] < 0) ? 0 : ev[k];
        end
    endtask

    // Behavioural reference: one cycle of the sequence trigger.
    task automatic model_step(input logic [7:0] e);
        bit got[4];
        for (int a = 0; a < 4; a++) got[a] = 0;
        for (int s = 0; s < 4; s++) begin
            int q[$];
            bit runs;
            for (int k = 0; k < 4; k++) if (!cfg_ign[s][k]) q.push_back(cfg_sel[s][k]);
            runs = (cfg_act[s] == 0) || m_coll;
            if (runs && q.size() > 0 && e[q[m_pos[s]]]) begin
                if (m_pos[s] == q.size() - 1) begin
                    got[cfg_act[s]] = 1;
                    m_pos[s] = 0;
                end else m_pos[s]++;
            end
        end
        e_start = got[0] && !got[3];
        e_asmp  = got[1];
        e_dsmp  = got[2];
        e_stop  = got[3];
        if (got[3]) begin
            m_coll = 0;
            for (int s = 0; s < 4; s++) m_pos[s] = 0;
        end else if (got[0]) m_coll = 1;
        e_coll = m_coll;
    endtask

    task automatic compare(input string tag);
        logic [4:0] a, x;
        a = {start_o, asmp_o, dsmp_o, stop_o, collecting_o};
        x = {e_start, e_asmp, e_dsmp, e_stop, e_coll};
        check(a == x, tag, int'(a), int'(x));
    endtask

    task automatic step(input logic [7:0] e, input string tag);
        evt_i = e;
        model_step(e);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        evt_i = '0;
        repeat (3) @(negedge clk);
        check({start_o, asmp_o, dsmp_o, stop_o, collecting_o} == 5'b0,
              "R1 reset outputs", int'({start_o, asmp_o, dsmp_o, stop_o, collecting_o}), 0);
        for (int s = 0; s < 4; s++) m_pos[s] = 0;
        m_coll = 0;
        {e_start, e_asmp, e_dsmp, e_stop, e_coll} = '0;
        rst_n = 1'b1;
    endtask

    task automatic random_run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(8'($urandom & $urandom & $urandom), tag);
    endtask

    localparam logic [7:0] E0 = 8'h01, E1 = 8'h02, E2 = 8'h04, E3 = 8'h08;
    localparam logic [7:0] E4 = 8'h10, E5 = 8'h20, E6 = 8'h40, E7 = 8'h80;

    initial begin
        int na, nd;
        // Configuration A: arm on event 0, sample address/data, stop after two pairs.
        set_seq(0, 0, 0, -1, -1, -1);
        set_seq(1, 1, 1, -1, -1, -1);
        set_seq(2, 2, 1, 2, -1, -1);
        set_seq(3, 3, 1, 2, 1, 2);
        do_reset();
        step(8'h00, "R1 first cycle");
        check(collecting_o == 1'b0, "R1 idle collecting", collecting_o, 0);

        // R8: transfers before arming are ignored.
        step(E1, "R8 closed");
        step(E2, "R8 closed");
        check(asmp_o == 1'b0 && dsmp_o == 1'b0, "R8 no samples closed",
              int'({asmp_o, dsmp_o}), 0);

        // R7/R6: open the window.
        step(E0, "R7 open");
        check(start_o && collecting_o, "R7 start opens", int'({start_o, collecting_o}), 3);
        step(8'h00, "R6 one-cycle strobe");
        check(start_o == 1'b0 && collecting_o, "R6 strobe width", int'({start_o, collecting_o}), 1);

        // R4/R11: two transfers then stop.
        na = 0; nd = 0;
        step(E1, "R11 first addr");  na += asmp_o;
        step(E2, "R11 first data");  nd += dsmp_o;
        check(stop_o == 1'b0, "R4 no stop after one pair", stop_o, 0);
        step(8'h00, "R4 gap");
        step(E1, "R11 second addr"); na += asmp_o;
        step(E2, "R4 second pair");  nd += dsmp_o;
        check(stop_o && !collecting_o, "R4 stop after two pairs", int'({stop_o, collecting_o}), 2);
        check(na == 2, "R11 address samples per window", na, 2);
        check(nd == 2, "R11 data samples per window", nd, 2);

        // R5: rearm and repeat.
        step(E1, "R8 after close");
        check(asmp_o == 1'b0, "R8 closed after stop", asmp_o, 0);
        step(E0, "R5 rearm");
        check(start_o == 1'b1, "R5 open again", start_o, 1);
        random_run(3000, "R2/R5/R6/R11 random config A");

        // Configuration B: gap wildcard open, never-firing sampler, one-event stop.
        set_seq(0, 0, -1, 6, -1, 7);
        set_seq(1, 1, -1, -1, -1, -1);
        set_seq(2, 2, 3, 4, -1, -1);
        set_seq(3, 3, -1, -1, -1, 5);
        do_reset();
        step(E7, "R2 out of order");
        check(start_o == 1'b0, "R2 wrong event ignored", start_o, 0);
        step(E6 | E7, "R2 one slot per cycle");
        check(start_o == 1'b0, "R2 single advance", start_o, 0);
        step(E7, "R3 gap wildcard");
        check(start_o == 1'b1, "R3 fires over wildcard", start_o, 1);

        // R9: stop wipes a half-done data sampler.
        step(E3, "R9 half pair");
        step(E5, "R9 stop");
        check(stop_o == 1'b1, "R9 stop fired", stop_o, 1);
        step(E6, "R9 reopen a");
        step(E7, "R9 reopen b");
        step(E4, "R9 lost progress");
        check(dsmp_o == 1'b0, "R9 progress cleared", dsmp_o, 0);
        step(E3, "R9 fresh pair a");
        step(E4, "R9 fresh pair b");
        check(dsmp_o == 1'b1, "R9 fresh pair fires", dsmp_o, 1);

        // R10: open and close in the same cycle.
        step(E6, "R10 prime open");
        step(E7 | E5, "R10 collision");
        check(stop_o && !start_o && !collecting_o, "R10 stop wins",
              int'({stop_o, start_o, collecting_o}), 4);

        // R3: an all-wildcard recogniser never fires.
        na = 0;
        for (int i = 0; i < 3000; i++) begin
            step(8'($urandom & $urandom & $urandom), "R3/R8/R10 random config B");
            na += asmp_o;
        end
        check(na == 0, "R3 all-wildcard silent", na, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule